// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register file behind a byte-addressed GPIO expander with one to five 8-bit ports. A bus slave outside the block turns serial traffic into three kinds of event on a byte-wide access port. A command byte loads the address pointer, a write beat stores one data byte, and a read beat fetches one. The pointer byte carries a register-group index and a port offset, packed as `group << SHIFT | port`. It also carries a bit that selects the extended register space and a bit that makes the pointer advance after every data beat.

The block drives the pad output enables and output values from its direction and output registers. It samples the pads through a two-flop synchroniser and returns them after polarity inversion. It can hold the first change seen on a pin until software reads the input register. It flags changes on unmasked input pins in a read-only status register. Pull-enable and pull-select values appear only as outputs, for pad logic elsewhere.

Top module: `gpx_regfile`

## Requirements
- R1: After reset every pad is an input (`pad_oe` all 0) and `pad_out` is all 1. The register contents are: output 0xFF, polarity 0x00, direction 0xFF, interrupt mask 0xFF, and input latch, pull enable and pull select 0x00. `pull_en` and `pull_sel` read 0.
- R2: Address bits [5:0] hold `group << SHIFT | port`. SHIFT is the bit length of NUM_PORTS-1, so SHIFT is 1 for two ports. With bit 6 clear, the groups are 0 input (read-only), 1 output, 2 polarity and 3 direction. With bit 6 set, the groups are 2 input latch, 3 pull enable, 4 pull select, 5 interrupt mask and 6 interrupt status (read-only).
- R3: For each pin, `pad_oe` is the inverse of its direction bit, where 1 means input. `pad_out` equals its output register bit.
- R4: A read of the input register returns the pad value, delayed by two synchroniser flops, XOR the polarity register.
- R5: When address bit 7 is set, each data beat advances address bits [5:0] by one, wrapping within those 6 bits. Bits 6 and 7 are kept. When bit 7 is clear, every beat hits the same register. A cycle with `cmd_valid` high only loads the pointer.
- R6: An access is invalid if the port offset is not below NUM_PORTS or the group is unmapped. Writes to the input or status register are also invalid. An invalid read returns 0x00 and an invalid write changes nothing. Either one raises `err`.
- R7: `rd_valid` is high for one cycle, the cycle after each read beat. `err` is a one-cycle pulse in the cycle after the offending beat.
- R8: An input-latch bit of 1 captures the first change of that pin relative to its value at the last input read. The input register keeps returning the captured value until the port's input register is read.
- R9: A status bit sets when a pin has direction input and mask 0, and its corrected value differs from its value at the last input read. Reading the port's input register clears the port's status. Reading the status register does not clear it.
- R10: `pull_en` and `pull_sel` present the pull-enable and pull-select registers bit for bit. A pull-select value of 1 means pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Load address pointer from `cmd_addr` |
| cmd_addr | input | 8 | Pointer byte: bit 7 auto-advance, bit 6 extended space, [5:0] group/port |
| wr_valid | input | 1 | Write beat |
| wr_data | input | 8 | Write data byte |
| rd_req | input | 1 | Read beat (ignored while `wr_valid` is high) |
| rd_valid | output | 1 | Read data valid, one cycle after the read beat |
| rd_data | output | 8 | Read data byte |
| err | output | 1 | Invalid access pulse |
| pad_in | input | NUM_PORTS*8 | Asynchronous pad inputs |
| pad_oe | output | NUM_PORTS*8 | Pad output enables |
| pad_out | output | NUM_PORTS*8 | Pad output values |
| pull_en | output | NUM_PORTS*8 | Pull resistor enables |
| pull_sel | output | NUM_PORTS*8 | Pull direction select (1 = up) |

## Verification
The checker relies on the bus slave issuing at most one event per cycle. It also relies on `cmd_valid` being high only in cycles that carry no data beat. The assertions about beats are therefore phrased on those inputs as the slave drives them. The bench drives exactly one of `cmd_valid`, `wr_valid` and `rd_req` for a single cycle, with idle cycles between events. It changes `pad_in` only between accesses and waits three cycles before sampling, so the synchroniser has settled before any read of the input or status register.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int PORT_BITS = 8;
    localparam int AI_BIT    = 7;
    localparam int EXT_BIT   = 6;

    typedef enum logic [3:0] {
        K_NONE, K_IN, K_OUT, K_POL, K_DIR,
        K_LATCH, K_PEN, K_PSEL, K_MASK, K_STAT
    } reg_kind_e;

    typedef struct packed {
        logic [PORT_BITS-1:0] outv;
        logic [PORT_BITS-1:0] pol;
        logic [PORT_BITS-1:0] dir;
        logic [PORT_BITS-1:0] latch;
        logic [PORT_BITS-1:0] pen;
        logic [PORT_BITS-1:0] psel;
        logic [PORT_BITS-1:0] mask;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{
        outv:  8'hFF, pol:  8'h00, dir:  8'hFF, latch: 8'h00,
        pen:   8'h00, psel: 8'h00, mask: 8'hFF
    };

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] port;
        logic       rd_ok;
        logic       wr_ok;
    } dec_t;

    // Bit length of (ports-1): the log2 of the group stride.
    function automatic int stride_shift(input int ports);
        int n;
        n = 0;
        for (int i = 0; i < 8; i++)
            if (((ports - 1) >> i) != 0) n = i + 1;
        return n;
    endfunction

    function automatic reg_kind_e group_kind(input logic ext, input logic [5:0] grp);
        reg_kind_e k;
        k = K_NONE;
        if (!ext) begin
            case (grp)
                6'd0: k = K_IN;
                6'd1: k = K_OUT;
                6'd2: k = K_POL;
                6'd3: k = K_DIR;
                default: k = K_NONE;
            endcase
        end else begin
            case (grp)
                6'd2: k = K_LATCH;
                6'd3: k = K_PEN;
                6'd4: k = K_PSEL;
                6'd5: k = K_MASK;
                6'd6: k = K_STAT;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/gpx_addr_decode.sv
module gpx_addr_decode
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic [7:0] addr,
    output dec_t       dec
);
    localparam int SHIFT = stride_shift(NUM_PORTS);

    logic [5:0] low;
    logic [5:0] grp;
    logic [5:0] prt;
    logic       in_range;
    reg_kind_e  kind;

    always_comb begin
        low      = addr[5:0];
        grp      = low >> SHIFT;
        prt      = low & ((6'd1 << SHIFT) - 6'd1);
        in_range = prt < 6'(NUM_PORTS);
        kind     = group_kind(addr[EXT_BIT], grp);
        dec.kind  = kind;
        dec.port  = prt[2:0];
        dec.rd_ok = in_range && (kind != K_NONE);
        dec.wr_ok = in_range && (kind != K_NONE) && (kind != K_IN) && (kind != K_STAT);
    end

endmodule

// File: rtl/gpx_pad_sync.sv
module gpx_pad_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
    import gpx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PORT_BITS-1:0] pad_sync,
    input  logic                 we,
    input  reg_kind_e            kind,
    input  logic [PORT_BITS-1:0] wdata,
    input  logic                 in_rd,
    output port_cfg_t            cfg,
    output logic [PORT_BITS-1:0] in_val,
    output logic [PORT_BITS-1:0] stat
);
    logic [PORT_BITS-1:0] live;
    logic [PORT_BITS-1:0] snap;
    logic [PORT_BITS-1:0] held_v;
    logic [PORT_BITS-1:0] held_d;
    logic [PORT_BITS-1:0] chg;
    logic [PORT_BITS-1:0] grab;

    always_comb begin
        live   = pad_sync ^ cfg.pol;
        chg    = live ^ snap;
        grab   = cfg.latch & chg & ~held_v;
        in_val = (held_v & held_d) | (~held_v & live);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (we) begin
            case (kind)
                K_OUT:   cfg.outv  <= wdata;
                K_POL:   cfg.pol   <= wdata;
                K_DIR:   cfg.dir   <= wdata;
                K_LATCH: cfg.latch <= wdata;
                K_PEN:   cfg.pen   <= wdata;
                K_PSEL:  cfg.psel  <= wdata;
                K_MASK:  cfg.mask  <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap   <= '0;
            held_v <= '0;
            held_d <= '0;
            stat   <= '0;
        end else if (in_rd) begin
            snap   <= live;
            held_v <= '0;
            stat   <= '0;
        end else begin
            held_v <= held_v | grab;
            held_d <= (held_d & ~grab) | (live & grab);
            stat   <= stat | (chg & cfg.dir & ~cfg.mask);
        end
    end

endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PINS = NUM_PORTS * PORT_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [7:0]      cmd_addr,
    input  logic            wr_valid,
    input  logic [7:0]      wr_data,
    input  logic            rd_req,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic            err,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pull_en,
    output logic [PINS-1:0] pull_sel
);
    logic [7:0]      ptr;
    dec_t            dec;
    logic            beat, do_wr, do_rd;
    logic [PINS-1:0] pad_s;
    logic [7:0]      rd_val;

    port_cfg_t       cfg_a  [NUM_PORTS];
    logic [7:0]      inv_a  [NUM_PORTS];
    logic [7:0]      stat_a [NUM_PORTS];

    gpx_addr_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (.addr(ptr), .dec(dec));

    gpx_pad_sync #(.WIDTH(PINS)) u_sync (.clk(clk), .rst(rst), .d(pad_in), .q(pad_s));

    assign beat  = !cmd_valid && (wr_valid || rd_req);
    assign do_wr = beat && wr_valid;
    assign do_rd = beat && !wr_valid;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel = (dec.port == 3'(p));
        gpx_port_regs u_port (
            .clk      (clk),
            .rst      (rst),
            .pad_sync (pad_s[p*PORT_BITS +: PORT_BITS]),
            .we       (do_wr && dec.wr_ok && sel),
            .kind     (dec.kind),
            .wdata    (wr_data),
            .in_rd    (do_rd && dec.rd_ok && sel && (dec.kind == K_IN)),
            .cfg      (cfg_a[p]),
            .in_val   (inv_a[p]),
            .stat     (stat_a[p])
        );
        assign pad_oe  [p*PORT_BITS +: PORT_BITS] = ~cfg_a[p].dir;
        assign pad_out [p*PORT_BITS +: PORT_BITS] = cfg_a[p].outv;
        assign pull_en [p*PORT_BITS +: PORT_BITS] = cfg_a[p].pen;
        assign pull_sel[p*PORT_BITS +: PORT_BITS] = cfg_a[p].psel;
    end

    always_comb begin
        rd_val = 8'h00;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec.rd_ok && dec.port == 3'(p)) begin
                case (dec.kind)
                    K_IN:    rd_val = inv_a[p];
                    K_OUT:   rd_val = cfg_a[p].outv;
                    K_POL:   rd_val = cfg_a[p].pol;
                    K_DIR:   rd_val = cfg_a[p].dir;
                    K_LATCH: rd_val = cfg_a[p].latch;
                    K_PEN:   rd_val = cfg_a[p].pen;
                    K_PSEL:  rd_val = cfg_a[p].psel;
                    K_MASK:  rd_val = cfg_a[p].mask;
                    K_STAT:  rd_val = stat_a[p];
                    default: rd_val = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= 8'h00;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
            err      <= 1'b0;
        end else begin
            if (cmd_valid)
                ptr <= cmd_addr;
            else if (beat && ptr[AI_BIT])
                ptr[5:0] <= ptr[5:0] + 6'd1;
            rd_valid <= do_rd;
            rd_data  <= do_rd ? rd_val : 8'h00;
            err      <= (do_wr && !dec.wr_ok) || (do_rd && !dec.rd_ok);
        end
    end

endmodule

// File: rtl/gpx_regfile_checker.sv
module gpx_regfile_checker #(
    parameter int PINS = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic            wr_valid,
    input logic            rd_req,
    input logic            rd_valid,
    input logic [7:0]      rd_data,
    input logic            err,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_out,
    input logic [PINS-1:0] pull_en,
    input logic [PINS-1:0] pull_sel
);
    // R7: a read beat yields read data in the next cycle
    assert_rd_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_valid && !cmd_valid) |=> rd_valid);

    // R7: no beat, no response of any kind
    assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || !(rd_req || wr_valid)) |=> (!rd_valid && !err));

    // R6: an invalid read returns zero
    assert_zero_on_err_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && err) |-> (rd_data == 8'h00));

    // R3 / R10: pad-facing outputs move only after a write beat
    assert_pads_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid || !wr_valid) |=> ($stable(pad_oe) && $stable(pad_out)
                                      && $stable(pull_en) && $stable(pull_sel)));

    // R7: responses are single-cycle pulses when beats are spaced
    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (err && !wr_valid && !rd_req) |=> !err);

endmodule

bind gpx_regfile gpx_regfile_checker #(.PINS(NUM_PORTS * 8)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .wr_valid(wr_valid),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .err(err),
    .pad_oe(pad_oe), .pad_out(pad_out), .pull_en(pull_en), .pull_sel(pull_sel)
);

// File: tb/gpx_regfile_test.sv
module gpx_regfile_test;
    localparam int NP   = 2;
    localparam int PINS = NP * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_addr = 8'h00;
    logic            wr_valid = 1'b0;
    logic [7:0]      wr_data = 8'h00;
    logic            rd_req = 1'b0;
    logic            rd_valid;
    logic [7:0]      rd_data;
    logic            err;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_oe, pad_out, pull_en, pull_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // kind codes: 0 none,1 in,2 out,3 pol,4 dir,5 latch,6 pull en,7 pull sel,8 mask,9 status
    logic [7:0] mdl [10][NP];

    always #5 clk = ~clk;

    gpx_regfile #(.NUM_PORTS(NP)) uut (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic int kind_of(input logic [7:0] a);
        int g, p;
        g = int'(a[5:0]) >> 1;
        p = int'(a[0]);
        if (p >= NP) return 0;
        if (!a[6]) return (g <= 3) ? g + 1 : 0;
        case (g)
            2: return 5; 3: return 6; 4: return 7; 5: return 8; 6: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] addr_of(input int k, input int p);
        int g;
        logic e;
        e = (k >= 5);
        case (k)
            1: g = 0; 2: g = 1; 3: g = 2; 4: g = 3;
            5: g = 2; 6: g = 3; 7: g = 4; 8: g = 5; default: g = 6;
        endcase
        return {1'b0, e, 6'(g * 2 + p)};
    endfunction

    task automatic cmd(input logic [7:0] a);
        @(negedge clk); cmd_valid = 1'b1; cmd_addr = a;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, output logic e);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0; e = err;
    endtask

    task automatic rd(output logic [7:0] d, output logic e);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        if (!rd_valid) chk("R7 rd_valid", 16'(rd_valid), 16'd1);
        d = rd_data; e = err;
    endtask

    task automatic setreg(input int k, input int p, input logic [7:0] v);
        logic e;
        cmd(addr_of(k, p));
        wr(v, e);
        mdl[k][p] = v;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] d;
        logic e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state at the pads
        chk("R1 pad_oe",   pad_oe,   16'h0000);
        chk("R1 pad_out",  pad_out,  16'hFFFF);
        chk("R1 pull_en",  pull_en,  16'h0000);
        chk("R1 pull_sel", pull_sel, 16'h0000);
        chk("R7 idle rd_valid", 16'(rd_valid), 16'd0);

        for (int p = 0; p < NP; p++) begin
            mdl[0][p] = 8'h00; mdl[1][p] = 8'h00; mdl[2][p] = 8'hFF;
            mdl[3][p] = 8'h00; mdl[4][p] = 8'hFF; mdl[5][p] = 8'h00;
            mdl[6][p] = 8'h00; mdl[7][p] = 8'h00; mdl[8][p] = 8'hFF;
            mdl[9][p] = 8'h00;
        end

        // R1 R2 R6: sweep every non-advancing address after reset
        for (int a = 0; a < 128; a++) begin
            int k;
            k = kind_of(8'(a));
            cmd(8'(a));
            rd(d, e);
            chk($sformatf("R2 reset read a=%02h", a), 16'(d), 16'(mdl[k][a & 1]));
            chk($sformatf("R6 reset err a=%02h", a), 16'(e), 16'(k == 0));
        end

        // R6: write sweep, invalid and read-only targets flagged and ignored
        for (int a = 0; a < 128; a++) begin
            int k;
            logic ok;
            k = kind_of(8'(a));
            ok = (k != 0) && (k != 1) && (k != 9);
            cmd(8'(a));
            wr(8'(a) ^ 8'hA5, e);
            chk($sformatf("R6 write err a=%02h", a), 16'(e), 16'(!ok));
            if (ok) mdl[k][a & 1] = 8'(a) ^ 8'hA5;
        end
        for (int a = 0; a < 128; a++) begin
            int k;
            k = kind_of(8'(a));
            cmd(8'(a));
            rd(d, e);
            if (k != 1 && k != 9)
                chk($sformatf("R2 readback a=%02h", a), 16'(d), 16'(mdl[k][a & 1]));
            chk($sformatf("R6 readback err a=%02h", a), 16'(e), 16'(k == 0));
        end

        // R3 R10: pad-facing outputs follow the registers
        chk("R3 pad_oe",    pad_oe,   {~mdl[4][1], ~mdl[4][0]});
        chk("R3 pad_out",   pad_out,  {mdl[2][1], mdl[2][0]});
        chk("R10 pull_en",  pull_en,  {mdl[6][1], mdl[6][0]});
        chk("R10 pull_sel", pull_sel, {mdl[7][1], mdl[7][0]});

        // R4: polarity-corrected input, read as an advancing burst (R5)
        for (int p = 0; p < NP; p++) begin
            setreg(5, p, 8'h00); setreg(4, p, 8'hFF); setreg(8, p, 8'hFF);
        end
        setreg(3, 0, 8'h0F); setreg(3, 1, 8'h00);
        pad_in = 16'h3C5A;
        settle();
        cmd(8'h80);
        rd(d, e); chk("R4 input p0", 16'(d), 16'h0055);
        rd(d, e); chk("R5 burst input p1", 16'(d), 16'h003C);

        // R5: advancing write burst crosses groups
        cmd(8'h82);
        wr(8'h11, e); wr(8'h22, e); wr(8'h33, e);
        cmd(8'h02); rd(d, e); chk("R5 burst out p0", 16'(d), 16'h0011);
        cmd(8'h03); rd(d, e); chk("R5 burst out p1", 16'(d), 16'h0022);
        cmd(8'h04); rd(d, e); chk("R5 burst pol p0", 16'(d), 16'h0033);
        chk("R3 pad_out burst", pad_out, 16'h2211);
        // R5: without the flag, beats hit one register
        cmd(8'h02);
        wr(8'h44, e); wr(8'h55, e);
        cmd(8'h02); rd(d, e); chk("R5 fixed out p0", 16'(d), 16'h0055);
        cmd(8'h03); rd(d, e); chk("R5 fixed out p1", 16'(d), 16'h0022);
        // R5: wrap of the low six bits
        cmd(8'hBF);
        rd(d, e); chk("R6 wrap first err", 16'(e), 16'd1);
        rd(d, e); chk("R5 wrap to input p0", 16'(d), 16'h0069);
        chk("R5 wrap err", 16'(e), 16'd0);
        setreg(3, 0, 8'h00);

        // R8: input latch holds the first change until read
        setreg(5, 0, 8'hFF);
        pad_in = 16'h0000; settle();
        cmd(8'h00); rd(d, e);
        pad_in = 16'h0001; settle();
        pad_in = 16'h0000; settle();
        cmd(8'h00);
        rd(d, e); chk("R8 latched", 16'(d), 16'h0001);
        rd(d, e); chk("R8 released", 16'(d), 16'h0000);
        pad_in = 16'h8000; settle();
        pad_in = 16'h0000; settle();
        cmd(8'h01); rd(d, e); chk("R8 no latch p1", 16'(d), 16'h0000);

        // R9: status on unmasked input pins, cleared by input read
        setreg(5, 0, 8'h00); setreg(8, 0, 8'hFE); setreg(4, 0, 8'hFF);
        cmd(8'h00); rd(d, e);
        pad_in = 16'h0003; settle();
        cmd(8'h4C);
        rd(d, e); chk("R9 status set", 16'(d), 16'h0001);
        rd(d, e); chk("R9 status kept", 16'(d), 16'h0001);
        cmd(8'h00); rd(d, e); chk("R4 input p0 again", 16'(d), 16'h0003);
        cmd(8'h4C); rd(d, e); chk("R9 status cleared", 16'(d), 16'h0000);
        setreg(4, 0, 8'hFE);
        pad_in = 16'h0000; settle();
        cmd(8'h4C); rd(d, e); chk("R9 output pin ignored", 16'(d), 16'h0000);
        chk("R3 pad_oe bit0", pad_oe, {~mdl[4][1], 8'h01});

        summary();
    end

endmodule